// File: doc/BRIEF.md
# Dual Clock Source Controller

This block chooses which of two oscillators drives the system clock and decides whether the fast main oscillator runs at all. Both oscillators are modelled as one-cycle tick enables on a common reference clock. A 4-bit control value is written over a simple register bus. Bit 0 picks the source, where 1 means the slow sub-oscillator. Bit 1 turns the main oscillator off when set. Bits 2 and 3 pass through unchanged to a divider and watchdog block.

A write that would switch off the main oscillator while it is still the selected source is refused. A sticky error flag records the refusal until the next read. A change of source does not take effect at once. The new source becomes active only after the target oscillator has produced a programmable number of ticks. Until the hand-over completes, the main oscillator is kept running if it is still the active source. The LCD clock always comes from the sub-oscillator and is silenced during STOP.

Top module: `dual_clk_src_ctl`

## Requirements
- R1: After reset the control value reads 0x0, cfg_err is 0, sys_src_sub is 0 (main active) and main_osc_en is 1.
- R2: A write whose data does not have bit 1 = 1 together with bit 0 = 0 is accepted, and rdata shows exactly that 4-bit value from the next cycle on.
- R3: A write whose data has bit 1 = 1 and bit 0 = 0 is rejected, and rdata keeps its previous value.
- R4: A rejected write sets cfg_err on the following cycle. A cycle with rd_en high clears it. When a rejected write and rd_en fall in the same cycle, cfg_err stays set.
- R5: When bit 0 differs from the active source, sys_src_sub changes at the clock edge that counts the SETTLE_TICKS-th tick of the target oscillator. sys_clk_en equals the tick of the active source (main_tick when sys_src_sub = 0, sub_tick when 1).
- R6: An accepted write that changes bit 0 while a switch is pending restarts the settle count. A later request needs SETTLE_TICKS new target ticks.
- R7: main_osc_en is 1 when bit 1 is 0. It is also 1 while the main oscillator is still the active source, even if bit 1 is 1. Otherwise it is 0.
- R8: lcd_clk_en equals sub_tick while stop is low and is 0 while stop is high. stop high also forces sys_clk_en to 0.
- R9: wdt_tap_sel equals bit 2 and div_short equals bit 3 of the accepted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | reference clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_en | input | 1 | write strobe for the control value |
| rd_en | input | 1 | read strobe, clears the error flag |
| wdata | input | 4 | write data |
| rdata | output | 4 | accepted control value |
| cfg_err | output | 1 | sticky flag for a refused write |
| main_tick | input | 1 | main oscillator tick |
| sub_tick | input | 1 | sub-oscillator tick |
| stop | input | 1 | STOP mode request |
| sys_clk_en | output | 1 | system clock enable from the active source |
| sys_src_sub | output | 1 | active source, 1 = sub-oscillator |
| main_osc_en | output | 1 | main oscillator run enable |
| lcd_clk_en | output | 1 | LCD clock enable |
| wdt_tap_sel | output | 1 | watchdog tap select (bit 2) |
| div_short | output | 1 | short divider select (bit 3) |

## Verification
The bench builds the block with SETTLE_TICKS = 3. With that setting, the edge where the switch completes and the restart after a cancelled request fall a few ticks apart, and the bench counts them directly. With ticks held low, it writes every one of the 16 values from every reachable register state. That covers all accept and reject decisions, together with the error flag and the exported bits. It also steps both switch directions, a cancelled request, and STOP against live sub-oscillator ticks.

// File: rtl/dual_clk_src_ctl.sv
module dual_clk_src_ctl #(
  parameter int SETTLE_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] wdata,
  output logic [3:0] rdata,
  output logic       cfg_err,
  input  logic       main_tick,
  input  logic       sub_tick,
  input  logic       stop,
  output logic       sys_clk_en,
  output logic       sys_src_sub,
  output logic       main_osc_en,
  output logic       lcd_clk_en,
  output logic       wdt_tap_sel,
  output logic       div_short
);

  localparam int CNT_W = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_TICKS - 1);

  logic [3:0]       ctl_q;
  logic             act_sub_q;
  logic             err_q;
  logic [CNT_W-1:0] cnt_q;

  logic wr_bad, wr_ok, pend, tgt_tick, flip;

  assign wr_bad = wr_en & wdata[1] & ~wdata[0];
  assign wr_ok  = wr_en & ~wr_bad;
  assign flip   = wr_ok & (wdata[0] != ctl_q[0]);

  assign main_osc_en = ~ctl_q[1] | ~act_sub_q;
  assign pend        = ctl_q[0] != act_sub_q;
  assign tgt_tick    = ctl_q[0] ? sub_tick : (main_tick & main_osc_en);

  assign sys_clk_en  = ~stop & (act_sub_q ? sub_tick : main_tick);
  assign lcd_clk_en  = ~stop & sub_tick;
  assign sys_src_sub = act_sub_q;
  assign rdata       = ctl_q;
  assign cfg_err     = err_q;
  assign wdt_tap_sel = ctl_q[2];
  assign div_short   = ctl_q[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= 4'h0;
      err_q <= 1'b0;
    end else begin
      if (wr_ok) ctl_q <= wdata;
      if (wr_bad)     err_q <= 1'b1;
      else if (rd_en) err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sub_q <= 1'b0;
      cnt_q     <= '0;
    end else if (flip || !pend) begin
      cnt_q <= '0;
    end else if (tgt_tick) begin
      if (cnt_q == CNT_LAST) begin
        act_sub_q <= ctl_q[0];
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_reject_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> rdata == $past(rdata));

  assert_reject_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> cfg_err);

  assert_no_forbidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdata[1] && !rdata[0]));

  assert_switch_to_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_src_sub != $past(sys_src_sub)) |-> (sys_src_sub == $past(rdata[0])));

  assert_main_on_at_handover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_src_sub) |-> $past(main_osc_en));

  assert_lcd_quiet_in_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !lcd_clk_en && !sys_clk_en);

endmodule

// File: tb/dual_clk_src_ctl_tb.sv
module dual_clk_src_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, main_tick = 1'b0, sub_tick = 1'b0, stop = 1'b0;
  logic [3:0] wdata = 4'h0;
  logic [3:0] rdata;
  logic cfg_err, sys_clk_en, sys_src_sub, main_osc_en, lcd_clk_en, wdt_tap_sel, div_short;

  int checks = 0, errors = 0;
  logic seen_sys;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_clk_src_ctl #(.SETTLE_TICKS(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .cfg_err(cfg_err), .main_tick(main_tick), .sub_tick(sub_tick),
    .stop(stop), .sys_clk_en(sys_clk_en), .sys_src_sub(sys_src_sub),
    .main_osc_en(main_osc_en), .lcd_clk_en(lcd_clk_en),
    .wdt_tap_sel(wdt_tap_sel), .div_short(div_short)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] v);
    @(negedge clk); wr_en = 1'b1; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic tick(input logic m, input logic s);
    @(negedge clk); main_tick = m; sub_tick = s;
    #1 seen_sys = sys_clk_en;
    @(negedge clk); main_tick = 1'b0; sub_tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] cur;
    logic bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", rdata, 0);
    chk("R1 err", cfg_err, 0);
    chk("R1 src", sys_src_sub, 0);
    chk("R1 main_en", main_osc_en, 1);

    for (int s = 0; s < 16; s++) begin
      if (s[1] && !s[0]) continue;
      for (int w = 0; w < 16; w++) begin
        wr(4'(s));
        cur = 4'(s);
        bad = w[1] && !w[0];
        wr(4'(w));
        if (!bad) cur = 4'(w);
        chk(bad ? "R3 kept" : "R2 accepted", rdata, cur);
        chk("R4 err set", cfg_err, bad);
        chk("R9 tap", wdt_tap_sel, cur[2]);
        chk("R9 div", div_short, cur[3]);
        chk("R7 main held while main active", main_osc_en, 1);
        rd();
        chk("R4 err cleared", cfg_err, 0);
      end
    end

    wr(4'h0);
    @(negedge clk); wr_en = 1'b1; wdata = 4'h2; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R4 set beats clear", cfg_err, 1);
    rd();

    wr(4'h1);
    tick(1'b1, 1'b0);
    chk("R5 sys follows main", seen_sys, 1);
    for (int i = 0; i < SETTLE - 1; i++) begin
      tick(1'b0, 1'b1);
      chk("R5 still main", sys_src_sub, 0);
    end
    tick(1'b0, 1'b1);
    chk("R5 switched to sub", sys_src_sub, 1);
    tick(1'b1, 1'b0);
    chk("R5 main tick ignored on sub", seen_sys, 0);
    tick(1'b0, 1'b1);
    chk("R5 sys follows sub", seen_sys, 1);

    wr(4'h3);
    chk("R7 main off", main_osc_en, 0);
    wr(4'h0);
    chk("R7 main on", main_osc_en, 1);
    for (int i = 0; i < SETTLE - 1; i++) tick(1'b1, 1'b0);
    wr(4'h1);
    wr(4'h0);
    for (int i = 0; i < SETTLE - 1; i++) begin
      tick(1'b1, 1'b0);
      chk("R6 count restarted", sys_src_sub, 1);
    end
    tick(1'b1, 1'b0);
    chk("R6 switched to main", sys_src_sub, 0);

    wr(4'h3);
    chk("R7 main held during pending", main_osc_en, 1);
    for (int i = 0; i < SETTLE; i++) tick(1'b0, 1'b1);
    chk("R7 main released after switch", main_osc_en, 0);

    @(negedge clk); stop = 1'b1; sub_tick = 1'b1;
    #1 chk("R8 lcd off in stop", lcd_clk_en, 0);
    chk("R8 sys off in stop", sys_clk_en, 0);
    @(negedge clk); stop = 1'b0;
    #1 chk("R8 lcd follows sub", lcd_clk_en, 1);
    @(negedge clk); sub_tick = 1'b0;
    #1 chk("R8 lcd idle", lcd_clk_en, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule